// File: doc/BRIEF.md
# Silent-Store Detector for a Load/Store Queue

This block keeps a value record alongside a load/store queue. Each memory operation pushes one entry when it enters the queue: its type, word address, byte-enable mask and data. A load records the value it returned; a store records the value it will write. Entries advance in step with the queue, so the record needs no tags and no replacement policy.

When a store enters, the block searches the older live entries for the same word address. It picks the youngest older entry whose bytes overlap the store's bytes. If that entry covers every byte of the store and holds equal data on those bytes, the store is tagged silent. The tag covers both kinds of older entry: an earlier load that read the same value, and an earlier store that wrote it. The tag travels with the entry and appears on the head outputs when the entry reaches commit. A memory barrier drives the flush input, which empties the record.

Top module: `ssd_detector`

## Requirements
- R1: After reset the record is empty: `head_valid_o` is 0 and `alloc_ready_o` is 1.
- R2: Entries retire in allocation order. The head outputs always show the oldest live entry: its type on `head_store_o` (1 = store, 0 = load) and its word address on `head_addr_o`.
- R3: With `DEPTH` live entries, `alloc_ready_o` is 0. An allocate request made while not ready is dropped.
- R4: A store is silent when the youngest overlapping older entry is a load that covers all of the store's enabled bytes with equal values.
- R5: A store is silent when the youngest overlapping older entry is a store that covers all of its enabled bytes with equal values.
- R6: Only enabled bytes are compared. A store whose enabled bytes differ from the deciding entry is not silent. Differences in bytes outside its mask have no effect.
- R7: Only the youngest overlapping older entry decides. If it differs, the store is not silent, even when an older entry matches.
- R8: If the deciding entry enables only some of the store's bytes (partial overlap), the store is not silent.
- R9: A load is never marked silent. A store with no overlapping older live entry is not silent, and entries that have already retired take no part in the search.
- R10: `flush_i` empties the record in one cycle and holds `alloc_ready_o` at 0 during that cycle. Stores allocated after a flush are not compared against entries from before it.
- R11: `commit_i` on an empty record has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Barrier flush: empties the record |
| alloc_valid_i | input | 1 | Allocate request |
| alloc_ready_o | output | 1 | Space available and no flush this cycle |
| alloc_store_i | input | 1 | 1 = store, 0 = load |
| alloc_addr_i | input | ADDR_W | Word address |
| alloc_be_i | input | DATA_W/8 | Byte-enable mask, bit n = byte n |
| alloc_data_i | input | DATA_W | Load result or store data |
| commit_i | input | 1 | Retire the head entry |
| head_valid_o | output | 1 | Head entry exists |
| head_store_o | output | 1 | Head entry is a store |
| head_addr_o | output | ADDR_W | Head entry word address |
| head_silent_o | output | 1 | Head store was found silent |

## Verification
The assertions assume the following about the inputs:
- The queue never raises an allocate request and a flush in the same cycle with the expectation that the entry is kept.
- Load data is already final when the load's entry is allocated.

The stimulus respects both. It always drives the final data at allocation, and it counts an allocate as accepted only when `alloc_ready_o` was high. The stimulus draws addresses from a pool of four words and byte values from two choices, so overlap, full coverage, partial coverage and equal data all occur often. Directed sequences cover the fill-to-full case, the barrier flush, a commit on an empty record, and an overlapping entry that is younger and different from a matching one.

// File: rtl/ssd_pkg.sv
package ssd_pkg;
  typedef enum logic {
    OP_LOAD  = 1'b0,
    OP_STORE = 1'b1
  } ssd_op_e;
endpackage

// File: rtl/ssd_entry_cmp.sv
module ssd_entry_cmp #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int BYTES = DATA_W / 8
) (
  input  logic              ent_valid_i,
  input  logic [ADDR_W-1:0] ent_addr_i,
  input  logic [BYTES-1:0]  ent_be_i,
  input  logic [DATA_W-1:0] ent_data_i,
  input  logic [ADDR_W-1:0] new_addr_i,
  input  logic [BYTES-1:0]  new_be_i,
  input  logic [DATA_W-1:0] new_data_i,
  output logic              alias_o,
  output logic              cover_o,
  output logic              equal_o
);
  logic [BYTES-1:0] byte_eq;

  for (genvar b = 0; b < BYTES; b++) begin : g_byte
    assign byte_eq[b] = (ent_data_i[8*b +: 8] == new_data_i[8*b +: 8]) || !new_be_i[b];
  end

  assign alias_o = ent_valid_i && (ent_addr_i == new_addr_i) && |(ent_be_i & new_be_i);
  assign cover_o = ((new_be_i & ~ent_be_i) == '0);
  assign equal_o = &byte_eq;
endmodule

// File: rtl/ssd_youngest_pick.sv
module ssd_youngest_pick #(
  parameter int DEPTH = 32,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DEPTH-1:0] hit_i,
  input  logic [PTR_W-1:0] head_i,
  output logic             found_o,
  output logic [PTR_W-1:0] slot_o
);
  logic [DEPTH-1:0] rot;
  logic [PTR_W-1:0] age;

  // rotate so bit 0 is the oldest slot
  always_comb begin
    for (int k = 0; k < DEPTH; k++) rot[k] = hit_i[head_i + PTR_W'(k)];
  end

  always_comb begin
    age = '0;
    for (int k = 0; k < DEPTH; k++) if (rot[k]) age = PTR_W'(k);
  end

  assign found_o = |rot;
  assign slot_o  = head_i + age;

  AST_PICK_IS_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_o |-> hit_i[slot_o]) else $error("pick not a hit"); // R7
endmodule

// File: rtl/ssd_detector.sv
module ssd_detector #(
  parameter int DEPTH  = 32,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int BYTES = DATA_W / 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              alloc_valid_i,
  output logic              alloc_ready_o,
  input  logic              alloc_store_i,
  input  logic [ADDR_W-1:0] alloc_addr_i,
  input  logic [BYTES-1:0]  alloc_be_i,
  input  logic [DATA_W-1:0] alloc_data_i,
  input  logic              commit_i,
  output logic              head_valid_o,
  output logic              head_store_o,
  output logic [ADDR_W-1:0] head_addr_o,
  output logic              head_silent_o
);
  import ssd_pkg::*;

  logic [DEPTH-1:0]  ent_valid;
  ssd_op_e           ent_op     [DEPTH];
  logic [ADDR_W-1:0] ent_addr   [DEPTH];
  logic [BYTES-1:0]  ent_be     [DEPTH];
  logic [DATA_W-1:0] ent_data   [DEPTH];
  logic              ent_silent [DEPTH];

  logic [PTR_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] cnt_q;
  logic full, alloc_fire, commit_fire;
  logic [DEPTH-1:0] hit, cov, eq;
  logic found;
  logic [PTR_W-1:0] pick_slot;
  logic new_silent;

  assign full          = (cnt_q == CNT_W'(DEPTH));
  assign alloc_ready_o = !full && !flush_i;
  assign alloc_fire    = alloc_valid_i && alloc_ready_o;
  assign commit_fire   = commit_i && ent_valid[head_q] && !flush_i;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    ssd_entry_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmp (
      .ent_valid_i (ent_valid[i]),
      .ent_addr_i  (ent_addr[i]),
      .ent_be_i    (ent_be[i]),
      .ent_data_i  (ent_data[i]),
      .new_addr_i  (alloc_addr_i),
      .new_be_i    (alloc_be_i),
      .new_data_i  (alloc_data_i),
      .alias_o     (hit[i]),
      .cover_o     (cov[i]),
      .equal_o     (eq[i])
    );
  end

  ssd_youngest_pick #(.DEPTH(DEPTH)) u_pick (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hit_i   (hit),
    .head_i  (head_q),
    .found_o (found),
    .slot_o  (pick_slot)
  );

  // youngest overlapping entry decides; it must cover and match
  assign new_silent = alloc_store_i && found && cov[pick_slot] && eq[pick_slot];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ent_valid <= '0;
      head_q    <= '0;
      tail_q    <= '0;
      cnt_q     <= '0;
    end else if (flush_i) begin
      ent_valid <= '0;
      head_q    <= '0;
      tail_q    <= '0;
      cnt_q     <= '0;
    end else begin
      if (commit_fire) begin
        ent_valid[head_q] <= 1'b0;
        head_q            <= head_q + 1'b1;
      end
      if (alloc_fire) begin
        ent_valid[tail_q] <= 1'b1;
        tail_q            <= tail_q + 1'b1;
      end
      cnt_q <= cnt_q + CNT_W'(alloc_fire) - CNT_W'(commit_fire);
    end
  end

  always_ff @(posedge clk_i) begin
    if (alloc_fire) begin
      ent_op[tail_q]     <= alloc_store_i ? OP_STORE : OP_LOAD;
      ent_addr[tail_q]   <= alloc_addr_i;
      ent_be[tail_q]     <= alloc_be_i;
      ent_data[tail_q]   <= alloc_data_i;
      ent_silent[tail_q] <= new_silent;
    end
  end

  assign head_valid_o  = ent_valid[head_q];
  assign head_store_o  = head_valid_o && (ent_op[head_q] == OP_STORE);
  assign head_addr_o   = head_valid_o ? ent_addr[head_q] : '0;
  assign head_silent_o = head_valid_o && ent_silent[head_q];

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full && alloc_valid_i && !commit_i && !flush_i |=> $stable(tail_q) && full) else $error("overflow"); // R3
  AST_FIRST_AT_HEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_fire && !head_valid_o |=> head_valid_o && head_addr_o == $past(alloc_addr_i)) else $error("order"); // R2
  AST_FLUSH_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !head_valid_o) else $error("flush"); // R10
  AST_LOAD_NOT_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    head_valid_o && !head_store_o |-> !head_silent_o) else $error("load silent"); // R9
  AST_EMPTY_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !head_valid_o && commit_i && !alloc_valid_i |=> !head_valid_o && $stable(head_q)) else $error("empty commit"); // R11
endmodule

// File: tb/tb_ssd_detector.sv
module tb_ssd_detector;
  localparam int DEPTH = 32, ADDR_W = 32, DATA_W = 32, BYTES = DATA_W / 8;

  logic clk = 0, rst_ni = 0;
  logic flush_i = 0, alloc_valid_i = 0, alloc_store_i = 0, commit_i = 0;
  logic [ADDR_W-1:0] alloc_addr_i = '0;
  logic [BYTES-1:0]  alloc_be_i = '0;
  logic [DATA_W-1:0] alloc_data_i = '0;
  logic alloc_ready_o, head_valid_o, head_store_o, head_silent_o;
  logic [ADDR_W-1:0] head_addr_o;

  int n_tests = 0, n_fail = 0;
  string cur_req = "R1";

  logic              m_st  [$];
  logic [ADDR_W-1:0] m_addr[$];
  logic [BYTES-1:0]  m_be  [$];
  logic [DATA_W-1:0] m_data[$];
  logic              m_sil [$];

  always #4 clk = ~clk;

  ssd_detector #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .flush_i(flush_i),
    .alloc_valid_i(alloc_valid_i), .alloc_ready_o(alloc_ready_o),
    .alloc_store_i(alloc_store_i), .alloc_addr_i(alloc_addr_i),
    .alloc_be_i(alloc_be_i), .alloc_data_i(alloc_data_i),
    .commit_i(commit_i), .head_valid_o(head_valid_o), .head_store_o(head_store_o),
    .head_addr_o(head_addr_o), .head_silent_o(head_silent_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] bmask(input logic [BYTES-1:0] be);
    logic [DATA_W-1:0] m = '0;
    for (int b = 0; b < BYTES; b++) if (be[b]) m[8*b +: 8] = 8'hff;
    return m;
  endfunction

  function automatic logic exp_silent(input logic st, input logic [ADDR_W-1:0] a,
                                      input logic [BYTES-1:0] be, input logic [DATA_W-1:0] d);
    if (!st) return 1'b0;
    for (int i = m_addr.size() - 1; i >= 0; i--)
      if (m_addr[i] == a && (m_be[i] & be) != '0)
        return ((be & ~m_be[i]) == '0) && (((m_data[i] ^ d) & bmask(be)) == '0);
    return 1'b0;
  endfunction

  task automatic check_head();
    logic ev = m_addr.size() != 0;
    chk(head_valid_o === ev, cur_req, "head_valid", 64'(head_valid_o), 64'(ev));
    if (ev) begin
      chk(head_store_o === m_st[0], cur_req, "head_store", 64'(head_store_o), 64'(m_st[0]));
      chk(head_addr_o === m_addr[0], cur_req, "head_addr", 64'(head_addr_o), 64'(m_addr[0]));
      chk(head_silent_o === m_sil[0], cur_req, "head_silent", 64'(head_silent_o), 64'(m_sil[0]));
    end
  endtask

  task automatic cyc(input logic av, input logic st, input logic [ADDR_W-1:0] a,
                     input logic [BYTES-1:0] be, input logic [DATA_W-1:0] d,
                     input logic cm, input logic fl);
    logic er, sil;
    @(negedge clk);
    check_head();
    alloc_valid_i = av; alloc_store_i = st; alloc_addr_i = a;
    alloc_be_i = be; alloc_data_i = d; commit_i = cm; flush_i = fl;
    #1;
    er = (m_addr.size() < DEPTH) && !fl;
    chk(alloc_ready_o === er, cur_req, "alloc_ready", 64'(alloc_ready_o), 64'(er));
    if (fl) begin
      m_st.delete(); m_addr.delete(); m_be.delete(); m_data.delete(); m_sil.delete();
    end else begin
      sil = exp_silent(st, a, be, d);
      if (cm && m_addr.size() != 0) begin
        void'(m_st.pop_front()); void'(m_addr.pop_front()); void'(m_be.pop_front());
        void'(m_data.pop_front()); void'(m_sil.pop_front());
      end
      if (av && er) begin
        m_st.push_back(st); m_addr.push_back(a); m_be.push_back(be);
        m_data.push_back(d); m_sil.push_back(sil);
      end
    end
  endtask

  task automatic push(input logic st, input logic [ADDR_W-1:0] a,
                      input logic [BYTES-1:0] be, input logic [DATA_W-1:0] d);
    cyc(1'b1, st, a, be, d, 1'b0, 1'b0);
  endtask

  task automatic pop();
    cyc(1'b0, 1'b0, '0, '0, '0, 1'b1, 1'b0);
  endtask

  task automatic drain();
    while (m_addr.size() != 0) pop();
  endtask

  function automatic logic [BYTES-1:0] rnd_be();
    case ($urandom % 7)
      0: return 4'b0001; 1: return 4'b0010; 2: return 4'b0100; 3: return 4'b1000;
      4: return 4'b0011; 5: return 4'b1100; default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] rnd_data();
    logic [DATA_W-1:0] d;
    for (int b = 0; b < BYTES; b++) d[8*b +: 8] = ($urandom % 2) ? 8'h5a : 8'h00;
    return d;
  endfunction

  initial begin
    #(8 * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    #20 rst_ni = 1;
    @(negedge clk);
    // R1 reset state
    chk(head_valid_o === 1'b0, "R1", "head_valid", 64'(head_valid_o), 0);
    chk(alloc_ready_o === 1'b1, "R1", "alloc_ready", 64'(alloc_ready_o), 1);

    cur_req = "R4";  // older load covers, equal bytes
    push(0, 32'h10, 4'b1111, 32'hcafe_1234); push(1, 32'h10, 4'b0011, 32'h0000_1234);
    drain();
    cur_req = "R5";  // older store equal
    push(1, 32'h20, 4'b1111, 32'h1111_2222); push(1, 32'h20, 4'b1111, 32'h1111_2222);
    drain();
    cur_req = "R6";  // enabled byte differs; then outside-mask differs only
    push(1, 32'h30, 4'b1111, 32'haabb_ccdd); push(1, 32'h30, 4'b0001, 32'haabb_cc00);
    push(1, 32'h30, 4'b0100, 32'h00bb_0000);
    drain();
    cur_req = "R7";  // matching load older than differing store
    push(0, 32'h40, 4'b1111, 32'h5); push(1, 32'h40, 4'b1111, 32'h6);
    push(1, 32'h40, 4'b1111, 32'h5);
    drain();
    cur_req = "R8";  // partial cover
    push(1, 32'h50, 4'b0011, 32'h7); push(1, 32'h50, 4'b1111, 32'h7);
    drain();
    cur_req = "R9";  // different address, load after store, retired entry
    push(1, 32'h60, 4'b1111, 32'h9); push(1, 32'h64, 4'b1111, 32'h9);
    push(0, 32'h60, 4'b1111, 32'h9);
    drain();
    push(1, 32'h60, 4'b1111, 32'h9);
    drain();
    cur_req = "R3";  // fill, overfill, drain in order
    for (int i = 0; i < DEPTH + 3; i++) push(i[0], 32'(i), 4'b1111, 32'(i));
    cur_req = "R2";
    drain();
    cur_req = "R10"; // flush then no match; alloc with flush dropped
    push(1, 32'h70, 4'b1111, 32'h3);
    cyc(1'b1, 1'b1, 32'h70, 4'b1111, 32'h3, 1'b0, 1'b1);
    push(1, 32'h70, 4'b1111, 32'h3);
    drain();
    cur_req = "R11"; // commit on empty
    pop(); pop();
    push(0, 32'h80, 4'b1111, 32'h1);
    drain();

    cur_req = "R7 random";
    for (int i = 0; i < 4000; i++)
      cyc(($urandom % 10) < 6, $urandom % 2, 32'($urandom % 4), rnd_be(), rnd_data(),
          ($urandom % 10) < 5, ($urandom % 100) == 0);
    drain();
    @(negedge clk);
    check_head();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule